// File: doc/BRIEF.md
# Dual-channel IDE register address decoder

This block sits between a host programmed-I/O port and the drives of a two-channel IDE controller. Each access address is compared against five programmable windows. These are the command block and the control block of each channel, plus one bus-master register window. The block reports which kind of region was hit, which channel the access belongs to, and the byte offset inside the window. An access that falls outside every window, or that uses a width the target register does not allow, is flagged.

For the task-file regions, the window that matched decides the channel. Inside the bus-master window, the offset decides it instead. Each channel keeps a drive-select bit, which the block snoops from byte writes to the drive/head select register. The channel and that bit together form a two-bit drive index, so up to four drives can be addressed. A 32-bit access to the data register is handed to the drive as two 16-bit requests on consecutive cycles, low half first. The host port is held off while the second half goes out.

Top module: `ide_pio_decode`

## Requirements
- R1: A window hits when its base <= address < base + size. Windows are checked in priority order: primary command, primary control, secondary command, secondary control, bus-master. `hit_offset` is the address minus the base of the winning window.
- R2: A window whose base input is zero never hits.
- R3: `hit_region` encodes the region: 0 = none, 1 = command block, 2 = control block, 3 = bus-master. For command and control hits, `hit_chan` is 0 for the primary windows and 1 for the secondary ones.
- R4: In the bus-master window, `hit_chan` is 0 for offsets below 8 and 1 for offsets 8 and above.
- R5: A valid access that hits no window raises `addr_err` and produces no drive request.
- R6: An accepted byte write to command-block offset 6 latches bit 4 of `acc_wdata` into that channel's select bit. Select bits reset to 0, and no other access changes them.
- R7: `drv_idx` is 2 × channel + select bit of that channel. On the select write itself, it already uses the newly written bit.
- R8: Access size is coded as 0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 = invalid. The data register (command offset 0) takes only codes 1 and 2. A code-1 access gives one drive request with `drv_half`=0. A code-2 access gives a request with `drv_half`=0, then a request with `drv_half`=1 on the next cycle with the same index and direction, and `acc_ready` is low during that second cycle.
- R9: All other command and control registers take only code 0. The bus-master window takes codes 0 to 2. Any other size raises `size_err` and produces no drive request and no select update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Host access present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Access address |
| acc_size | input | 2 | Size code (R8) |
| acc_wdata | input | 8 | Low write data byte |
| win_base | input | 5×AW | Window bases, index 0..4 in R1 order |
| win_size | input | 5×AW | Window sizes, same order |
| acc_ready | output | 1 | Low while a split second half is issued |
| hit_region | output | 2 | Region code (R3) |
| hit_chan | output | 1 | Channel of the access |
| hit_offset | output | AW | Offset inside the window |
| addr_err | output | 1 | Access hit no window |
| size_err | output | 1 | Width not allowed for the register |
| drv_req | output | 1 | Request to a drive |
| drv_wr | output | 1 | Direction of the drive request |
| drv_half | output | 1 | 0 = low or only half, 1 = high half |
| drv_idx | output | 2 | Target drive index |

## Verification
The high half of a split 32-bit data transfer goes out in the cycle after the host access was accepted. A new host access can be presented in that same cycle. The bench provokes this by holding a select write to the secondary channel on the port during the second half. It then checks three things. The drive request must still carry the high half, the index and the direction of the original access. `acc_ready` must be low. The secondary select bit must stay unchanged until the write is presented again and accepted.

// File: rtl/ide_pio_decode.sv
module ide_pio_decode #(
  parameter int AW         = 16,
  parameter int SEL_OFF    = 6,
  parameter int DEV_BIT    = 4,
  parameter int BM_SEC_OFF = 8,
  parameter int DATA_OFF   = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic                  acc_write,
  input  logic [AW-1:0]         acc_addr,
  input  logic [1:0]            acc_size,
  input  logic [7:0]            acc_wdata,
  input  logic [4:0][AW-1:0]    win_base,
  input  logic [4:0][AW-1:0]    win_size,
  output logic                  acc_ready,
  output logic [1:0]            hit_region,
  output logic                  hit_chan,
  output logic [AW-1:0]         hit_offset,
  output logic                  addr_err,
  output logic                  size_err,
  output logic                  drv_req,
  output logic                  drv_wr,
  output logic                  drv_half,
  output logic [1:0]            drv_idx
);
  localparam int NWIN = 5;
  localparam logic [1:0] RG_NONE = 2'd0;
  localparam logic [1:0] RG_CMD  = 2'd1;
  localparam logic [1:0] RG_CTL  = 2'd2;
  localparam logic [1:0] RG_BM   = 2'd3;
  localparam logic [1:0] SZ_B    = 2'd0;
  localparam logic [1:0] SZ_H    = 2'd1;
  localparam logic [1:0] SZ_W    = 2'd2;

  logic [NWIN-1:0]         win_hit;
  logic [NWIN-1:0][AW-1:0] win_rel;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign win_rel[w] = acc_addr - win_base[w];
    assign win_hit[w] = (win_base[w] != '0) && (acc_addr >= win_base[w]) &&
                        (win_rel[w] < win_size[w]);
  end

  always_comb begin
    hit_region = RG_NONE;
    hit_chan   = 1'b0;
    hit_offset = '0;
    if (win_hit[0]) begin
      hit_region = RG_CMD; hit_offset = win_rel[0];
    end else if (win_hit[1]) begin
      hit_region = RG_CTL; hit_offset = win_rel[1];
    end else if (win_hit[2]) begin
      hit_region = RG_CMD; hit_chan = 1'b1; hit_offset = win_rel[2];
    end else if (win_hit[3]) begin
      hit_region = RG_CTL; hit_chan = 1'b1; hit_offset = win_rel[3];
    end else if (win_hit[4]) begin
      hit_region = RG_BM;  hit_offset = win_rel[4];
      hit_chan   = (win_rel[4] >= AW'(BM_SEC_OFF));
    end
  end

  logic is_data, size_ok, taskfile, accept, sel_wr, cur_sel;
  logic [1:0] sel;
  logic       pend, pend_wr;
  logic [1:0] pend_idx;

  assign taskfile = (hit_region == RG_CMD) || (hit_region == RG_CTL);
  assign is_data  = (hit_region == RG_CMD) && (hit_offset == AW'(DATA_OFF));

  always_comb begin
    case (hit_region)
      RG_NONE: size_ok = 1'b0;
      RG_BM:   size_ok = (acc_size != 2'd3);
      default: size_ok = is_data ? (acc_size == SZ_H || acc_size == SZ_W)
                                 : (acc_size == SZ_B);
    endcase
  end

  assign acc_ready = !pend;
  assign addr_err  = acc_valid && (hit_region == RG_NONE);
  assign size_err  = acc_valid && (hit_region != RG_NONE) && !size_ok;
  assign accept    = acc_valid && acc_ready && taskfile && size_ok;
  assign sel_wr    = accept && acc_write && (hit_region == RG_CMD) &&
                     (hit_offset == AW'(SEL_OFF));
  assign cur_sel   = sel_wr ? acc_wdata[DEV_BIT] : sel[hit_chan];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel      <= 2'b00;
      pend     <= 1'b0;
      pend_wr  <= 1'b0;
      pend_idx <= 2'd0;
    end else begin
      if (sel_wr) sel[hit_chan] <= acc_wdata[DEV_BIT];
      pend <= accept && is_data && (acc_size == SZ_W);
      if (accept) begin
        pend_wr  <= acc_write;
        pend_idx <= {hit_chan, cur_sel};
      end
    end
  end

  assign drv_req  = pend || accept;
  assign drv_half = pend;
  assign drv_wr   = pend ? pend_wr  : acc_write;
  assign drv_idx  = pend ? pend_idx : {hit_chan, cur_sel};

  p_split_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_data && acc_size == SZ_W) |=> (drv_req && drv_half && !acc_ready));
  p_split_same_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drv_half |-> (drv_idx == $past(drv_idx) && drv_wr == $past(drv_wr)));
  p_miss_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_err && !drv_half) |-> (!drv_req && hit_region == RG_NONE));
  p_badsize_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (size_err && !drv_half) |-> !drv_req);
  p_sel_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write && acc_ready) |=> $stable(sel));
  p_idx_chan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_req && !drv_half) |-> (drv_idx[1] == hit_chan));
endmodule

// File: tb/sim_ide_pio_decode.sv
module sim_ide_pio_decode;
  localparam int PERIOD = 10;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0] acc_size = '0;
  logic [7:0] acc_wdata = '0;
  logic [4:0][AW-1:0] win_base, win_size;
  logic acc_ready, hit_chan, addr_err, size_err, drv_req, drv_wr, drv_half;
  logic [1:0] hit_region, drv_idx;
  logic [AW-1:0] hit_offset;
  int n_run = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  ide_pio_decode #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .win_base(win_base), .win_size(win_size), .acc_ready(acc_ready),
    .hit_region(hit_region), .hit_chan(hit_chan), .hit_offset(hit_offset),
    .addr_err(addr_err), .size_err(size_err), .drv_req(drv_req),
    .drv_wr(drv_wr), .drv_half(drv_half), .drv_idx(drv_idx));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic put(logic w, logic [AW-1:0] a, logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_size = s; acc_wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    acc_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    check("R6 reset ready", {31'd0, acc_ready}, 1);
    check("R6 reset no req", {31'd0, drv_req}, 0);
    put(0, 16'h01F0, 2'd1, 0);
    check("R6 reset idx primary", {30'd0, drv_idx}, 0);
    idle();
  endtask

  task automatic t_windows();
    put(0, 16'h01F3, 2'd0, 0);
    check("R3 pcmd region", {30'd0, hit_region}, 1);
    check("R1 pcmd offset", {16'd0, hit_offset}, 3);
    check("R3 pcmd chan", {31'd0, hit_chan}, 0);
    put(0, 16'h01F8, 2'd0, 0);
    check("R1 end excluded", {31'd0, addr_err}, 1);
    check("R5 miss no req", {31'd0, drv_req}, 0);
    put(0, 16'h03F5, 2'd0, 0);
    check("R3 pctl region", {30'd0, hit_region}, 2);
    check("R1 pctl offset", {16'd0, hit_offset}, 1);
    put(0, 16'h0172, 2'd0, 0);
    check("R3 scmd chan", {31'd0, hit_chan}, 1);
    check("R1 scmd offset", {16'd0, hit_offset}, 2);
    put(0, 16'h0377, 2'd0, 0);
    check("R3 sctl region/chan", {29'd0, hit_region, hit_chan}, 5);
    idle();
  endtask

  task automatic t_disable();
    win_base[1] = '0;
    put(0, 16'h03F5, 2'd0, 0);
    check("R2 zero base misses", {31'd0, addr_err}, 1);
    idle();
    win_base[1] = 16'h03F4;
  endtask

  task automatic t_busmaster();
    put(0, 16'hC002, 2'd0, 0);
    check("R4 bm low chan", {29'd0, hit_region, hit_chan}, 6);
    check("R4 bm no drive req", {31'd0, drv_req}, 0);
    put(0, 16'hC00A, 2'd2, 0);
    check("R4 bm high chan", {29'd0, hit_region, hit_chan}, 7);
    check("R4 bm offset", {16'd0, hit_offset}, 10);
    put(0, 16'hC008, 2'd1, 0);
    check("R4 bm boundary chan", {31'd0, hit_chan}, 1);
    check("R9 bm half ok", {31'd0, size_err}, 0);
    put(0, 16'hC000, 2'd3, 0);
    check("R9 bm bad size", {31'd0, size_err}, 1);
    idle();
  endtask

  task automatic t_select();
    put(1, 16'h01F6, 2'd0, 8'h10);
    check("R7 idx on select write", {30'd0, drv_idx}, 1);
    idle();
    put(0, 16'h01F0, 2'd1, 0);
    check("R6 primary sel set", {30'd0, drv_idx}, 1);
    put(0, 16'h0170, 2'd1, 0);
    check("R7 secondary idx", {30'd0, drv_idx}, 2);
    put(1, 16'h0176, 2'd0, 8'hFF);
    check("R7 secondary slave idx", {30'd0, drv_idx}, 3);
    put(1, 16'h01F6, 2'd0, 8'hEF);
    check("R6 clear primary", {30'd0, drv_idx}, 0);
    put(1, 16'h01F2, 2'd0, 8'hFF);
    idle();
    put(0, 16'h01F0, 2'd1, 0);
    check("R6 other reg ignored", {30'd0, drv_idx}, 0);
    put(0, 16'h0170, 2'd1, 0);
    check("R6 secondary kept", {30'd0, drv_idx}, 3);
    put(1, 16'h0176, 2'd1, 8'h00);
    check("R9 select half rejected", {31'd0, size_err}, 1);
    idle();
    put(0, 16'h0170, 2'd1, 0);
    check("R9 no select update", {30'd0, drv_idx}, 3);
    idle();
  endtask

  task automatic t_sizes();
    put(0, 16'h01F0, 2'd0, 0);
    check("R8 data byte rejected", {31'd0, size_err}, 1);
    check("R8 data byte no req", {31'd0, drv_req}, 0);
    put(0, 16'h01F2, 2'd1, 0);
    check("R9 reg half rejected", {31'd0, size_err}, 1);
    put(0, 16'h03F6, 2'd0, 0);
    check("R9 ctl byte ok", {30'd0, drv_req, size_err}, 2);
    put(1, 16'h0170, 2'd1, 0);
    check("R8 half single", {29'd0, drv_req, drv_half, drv_wr}, 5);
    idle();
    check("R8 half no second", {30'd0, drv_req, acc_ready}, 1);
  endtask

  task automatic t_split();
    put(1, 16'h0170, 2'd2, 0);
    check("R8 split low", {28'd0, drv_req, drv_half, drv_idx}, 11);
    @(negedge clk);
    acc_write = 1'b1; acc_addr = 16'h0176; acc_size = 2'd0; acc_wdata = 8'h00;
    #1;
    check("R8 split high", {27'd0, drv_req, drv_half, drv_wr, drv_idx}, 31);
    check("R8 ready low", {31'd0, acc_ready}, 0);
    idle();
    check("R8 split done", {30'd0, drv_req, acc_ready}, 1);
    put(0, 16'h0170, 2'd1, 0);
    check("R6 stalled write ignored", {30'd0, drv_idx}, 3);
    put(1, 16'h0176, 2'd0, 8'h00);
    idle();
    put(0, 16'h0170, 2'd1, 0);
    check("R6 retried write taken", {30'd0, drv_idx}, 2);
    idle();
  endtask

  initial begin
    win_base[0] = 16'h01F0; win_size[0] = 16'd8;
    win_base[1] = 16'h03F4; win_size[1] = 16'd4;
    win_base[2] = 16'h0170; win_size[2] = 16'd8;
    win_base[3] = 16'h0374; win_size[3] = 16'd4;
    win_base[4] = 16'hC000; win_size[4] = 16'd16;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_windows();
    t_disable();
    t_busmaster();
    t_select();
    t_sizes();
    t_split();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule